// File: doc/BRIEF.md
# Receive Descriptor-Chain DMA Engine

This block moves received frames out of a receive FIFO and into host memory. The host builds a chain of descriptors in memory. Each descriptor names the next descriptor, holds a status word and lists one or more buffer fragments. The host writes the address of the first descriptor into the engine. For each frame waiting in the FIFO, the engine reads the descriptor's status, then reads the fragment address and length pairs one at a time. It streams the frame bytes into those fragments and writes back a status word with a done flag, the frame length and an error flag. It then follows the next pointer and pulses a per-frame interrupt.

A descriptor whose done flag is already set still belongs to the host. With a zero poll period the engine stops on its own and waits for a resume. With a non-zero poll period it re-reads the flag each period until the host clears it. Either behaviour lets the chain be closed into a ring. Reception is gated by enable and disable pulses, and a disable that arrives mid-frame waits for that frame to finish. Halt and resume pulses let the host stop the engine between frames while it edits pointers.

The memory port is a plain request/acknowledge master. A request and its address are held until a one-cycle acknowledge returns, and read data is valid with that acknowledge.

Top module: `rxd_dma`

## Requirements
- R1: After reset `list_ptr` is 0, `rx_ready` is low, `irq` is low and no memory request is issued.
- R2: While reception has not been enabled by an `rx_en` pulse, a waiting frame is not taken: `rx_ready` stays low and its descriptor is not touched.
- R3: An `rx_dis` pulse during a frame lets that frame complete with its status written. Afterwards no new frame is taken until the next `rx_en`.
- R4: Writing a non-zero value with `lp_wr` starts processing. After a frame the list pointer takes the descriptor's next-pointer word, and a zero next pointer leaves `list_ptr` at 0 with the engine idle. `rx_ready` is only high while `list_ptr` is non-zero.
- R5: Descriptor layout, in 32-bit words at byte offsets from the descriptor base:
  - +0 is the next pointer.
  - +4 is the status.
  - Fragment k has its address at +8+8k and its length at +12+8k.
  - In a length word, bits 12:0 are the byte count and bit 31 marks the last fragment.
  - Memory requests hold their address until acknowledged.
- R6: Frame bytes are written in order, one byte write per byte, filling each fragment to its full length before the next fragment's pair is fetched. Bytes beyond a fragment's length are not written there.
- R7: On frame completion the engine writes a status word with bit 15 set, bit 14 clear for a clean frame and bits 12:0 equal to the frame length in bytes. `irq` is then a single-cycle pulse, once per frame.
- R8: The error flag (bit 14) is set in the status word in two cases. The first is a frame longer than the total fragment space: its excess bytes are drained from the FIFO and discarded, and the length still counts every byte. The second is a frame whose last byte carries `rx_err`. The descriptor completes in both cases.
- R9: A `halt` pulse stops the engine before it takes another frame, and a `resume` pulse lets it continue.
- R10: If a descriptor's status already has bit 15 set and `poll_period` is 0, the engine halts by itself. It writes nothing, keeps `list_ptr`, raises no `irq`, and retries after `resume`.
- R11: If a descriptor's status already has bit 15 set and `poll_period` is non-zero, the engine re-reads that status word repeatedly at that period. It proceeds without a resume once the flag is clear.
- R12: A 1518-byte frame fits a single 1518-byte fragment and is reported with length 1518 and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Pulse: enable reception |
| rx_dis | input | 1 | Pulse: disable reception after current frame |
| halt | input | 1 | Pulse: stop engine between frames |
| resume | input | 1 | Pulse: clear halt (explicit or implicit) |
| lp_wr | input | 1 | Write strobe for the list pointer |
| lp_wdata | input | 32 | List pointer value to write |
| poll_period | input | 16 | Re-poll interval in cycles, 0 = halt on owned descriptor |
| rx_valid | input | 1 | FIFO byte valid |
| rx_data | input | 8 | FIFO byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err | input | 1 | Frame error, qualified by rx_last |
| rx_ready | output | 1 | Engine takes the FIFO byte this cycle |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_byte | output | 1 | Write is a single byte (low 8 bits of mem_wdata) |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| list_ptr | output | 32 | Current descriptor address |
| irq | output | 1 | Per-frame completion pulse |

## Verification
The transfer path is driven with three layouts. A short frame in one roomy fragment shows basic placement and status. A frame split across a small and a large fragment, followed by a second frame through the chained descriptor, shows fragment ordering, the pair fetch at the right offsets and pointer following. A frame longer than its only fragment shows the overflow cut-off, because a guard byte just past the fragment must remain untouched. A full 1518-byte frame checks the length field at its largest practical value. Descriptors already marked done are presented with zero and non-zero poll periods to separate the stop-and-resume path from the timed re-read path, and counting status reads confirms the re-reading. Disable, halt and enable pulses are placed before and inside frames to show which frame boundaries each one respects.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    // descriptor word offsets (bytes from descriptor base)
    localparam int unsigned OFS_NEXT   = 0;
    localparam int unsigned OFS_STATUS = 4;
    localparam int unsigned OFS_FRAG   = 8;
    localparam int unsigned FRAG_PAIR_SHIFT = 3;

    // status / length word fields
    localparam int unsigned LEN_W        = 13;
    localparam int unsigned STAT_DONE    = 15;
    localparam int unsigned STAT_ERR     = 14;
    localparam int unsigned FRAG_LASTBIT = 31;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_POLL,
        ST_RD_ADDR,
        ST_RD_LEN,
        ST_XFER,
        ST_WR_BYTE,
        ST_DRAIN,
        ST_WR_STAT,
        ST_RD_NEXT
    } eng_state_e;

endpackage

// File: rtl/rxd_gate.sv
module rxd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic rx_dis,
    input  logic frame_start,
    input  logic frame_done,
    output logic accept
);

    typedef struct packed {
        logic enabled;
        logic pend_off;
        logic active;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (frame_start) begin
            g_d.active = 1'b1;
        end
        if (frame_done) begin
            g_d.active = 1'b0;
            if (g_q.pend_off) begin
                g_d.enabled  = 1'b0;
                g_d.pend_off = 1'b0;
            end
        end
        if (rx_dis) begin
            if (g_q.active || frame_start) begin
                g_d.pend_off = 1'b1;
            end else begin
                g_d.enabled = 1'b0;
            end
        end
        if (rx_en) begin
            g_d.enabled  = 1'b1;
            g_d.pend_off = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign accept = g_q.enabled && !g_q.pend_off;

endmodule

// File: rtl/rxd_poll_timer.sv
module rxd_poll_timer #(
    parameter int unsigned PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cancel,
    input  logic [PW-1:0] period,
    output logic          expired
);

    typedef struct packed {
        logic          run;
        logic [PW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        expired = t_q.run && (t_q.cnt <= PW'(1));
        if (t_q.run) begin
            if (expired) begin
                t_d.run = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt - PW'(1);
            end
        end
        if (cancel) begin
            t_d.run = 1'b0;
        end
        if (start) begin
            t_d.run = 1'b1;
            t_d.cnt = period;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
    import rxd_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter int unsigned MAX_FRAGS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt,
    input  logic          resume,
    input  logic          lp_wr,
    input  logic [AW-1:0] lp_wdata,
    input  logic          poll_zero,
    input  logic          poll_expired,
    output logic          poll_start,
    output logic          poll_cancel,
    input  logic          accept,
    output logic          frame_start,
    output logic          frame_done,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic          rx_err,
    output logic          rx_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_byte,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic [AW-1:0] list_ptr,
    output logic          irq
);

    localparam int unsigned FW = (MAX_FRAGS > 1) ? $clog2(MAX_FRAGS) : 1;
    localparam logic [FW-1:0] FRAG_MAX_IDX = FW'(MAX_FRAGS - 1);

    typedef struct packed {
        eng_state_e      st;
        logic [AW-1:0]   lp;
        logic            halted;
        logic [FW-1:0]   frag;
        logic [AW-1:0]   buf_addr;
        logic [LEN_W-1:0] flen;
        logic [LEN_W-1:0] foff;
        logic            flast;
        logic [LEN_W-1:0] frame_len;
        logic            err;
        logic [7:0]      byte_q;
        logic            end_seen;
        logic            irq;
    } eng_t;

    eng_t r_d, r_q;

    logic [AW-1:0]   pair_base;
    logic [31:0]     stat_word;
    logic [LEN_W-1:0] len_inc;

    assign pair_base = r_q.lp + AW'(OFS_FRAG) + AW'({r_q.frag, {FRAG_PAIR_SHIFT{1'b0}}});
    assign len_inc   = (r_q.frame_len == '1) ? r_q.frame_len : r_q.frame_len + LEN_W'(1);

    always_comb begin
        stat_word = '0;
        stat_word[STAT_DONE]   = 1'b1;
        stat_word[STAT_ERR]    = r_q.err;
        stat_word[LEN_W-1:0]   = r_q.frame_len;
    end

    always_comb begin
        r_d         = r_q;
        r_d.irq     = 1'b0;
        poll_start  = 1'b0;
        poll_cancel = 1'b0;
        frame_start = 1'b0;
        frame_done  = 1'b0;
        rx_ready    = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_byte    = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;

        if (halt) begin
            r_d.halted = 1'b1;
        end else if (resume) begin
            r_d.halted = 1'b0;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if ((r_q.lp != '0) && !r_q.halted && accept && rx_valid) begin
                    frame_start   = 1'b1;
                    r_d.frame_len = '0;
                    r_d.err       = 1'b0;
                    r_d.frag      = '0;
                    r_d.end_seen  = 1'b0;
                    r_d.st        = ST_RD_STAT;
                end
            end
            ST_RD_STAT: begin
                mem_req  = 1'b1;
                mem_addr = r_q.lp + AW'(OFS_STATUS);
                if (mem_ack) begin
                    if (mem_rdata[STAT_DONE]) begin
                        if (poll_zero) begin
                            r_d.halted = 1'b1;
                            frame_done = 1'b1;
                            r_d.st     = ST_IDLE;
                        end else begin
                            poll_start = 1'b1;
                            r_d.st     = ST_POLL;
                        end
                    end else begin
                        r_d.st = ST_RD_ADDR;
                    end
                end
            end
            ST_POLL: begin
                if (r_q.halted) begin
                    poll_cancel = 1'b1;
                    frame_done  = 1'b1;
                    r_d.st      = ST_IDLE;
                end else if (poll_expired) begin
                    r_d.st = ST_RD_STAT;
                end
            end
            ST_RD_ADDR: begin
                mem_req  = 1'b1;
                mem_addr = pair_base;
                if (mem_ack) begin
                    r_d.buf_addr = mem_rdata[AW-1:0];
                    r_d.st       = ST_RD_LEN;
                end
            end
            ST_RD_LEN: begin
                mem_req  = 1'b1;
                mem_addr = pair_base + AW'(4);
                if (mem_ack) begin
                    r_d.flen  = mem_rdata[LEN_W-1:0];
                    r_d.flast = mem_rdata[FRAG_LASTBIT] || (r_q.frag == FRAG_MAX_IDX);
                    r_d.foff  = '0;
                    r_d.st    = ST_XFER;
                end
            end
            ST_XFER: begin
                if (r_q.foff == r_q.flen) begin
                    if (r_q.flast) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_DRAIN;
                    end else begin
                        r_d.frag = r_q.frag + FW'(1);
                        r_d.st   = ST_RD_ADDR;
                    end
                end else begin
                    rx_ready = 1'b1;
                    if (rx_valid) begin
                        r_d.byte_q    = rx_data;
                        r_d.end_seen  = rx_last;
                        r_d.err       = r_q.err | (rx_last & rx_err);
                        r_d.frame_len = len_inc;
                        r_d.st        = ST_WR_BYTE;
                    end
                end
            end
            ST_WR_BYTE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_byte  = 1'b1;
                mem_addr  = r_q.buf_addr + AW'(r_q.foff);
                mem_wdata = {24'd0, r_q.byte_q};
                if (mem_ack) begin
                    r_d.foff = r_q.foff + LEN_W'(1);
                    r_d.st   = r_q.end_seen ? ST_WR_STAT : ST_XFER;
                end
            end
            ST_DRAIN: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    r_d.frame_len = len_inc;
                    if (rx_last) begin
                        r_d.st = ST_WR_STAT;
                    end
                end
            end
            ST_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.lp + AW'(OFS_STATUS);
                mem_wdata = stat_word;
                if (mem_ack) begin
                    r_d.st = ST_RD_NEXT;
                end
            end
            ST_RD_NEXT: begin
                mem_req  = 1'b1;
                mem_addr = r_q.lp + AW'(OFS_NEXT);
                if (mem_ack) begin
                    r_d.lp     = mem_rdata[AW-1:0];
                    r_d.irq    = 1'b1;
                    frame_done = 1'b1;
                    r_d.st     = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (lp_wr) begin
            r_d.lp = lp_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign list_ptr = r_q.lp;
    assign irq      = r_q.irq;

endmodule

// File: rtl/rxd_dma.sv
module rxd_dma #(
    parameter int unsigned AW        = 32,
    parameter int unsigned PW        = 16,
    parameter int unsigned MAX_FRAGS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          rx_dis,
    input  logic          halt,
    input  logic          resume,
    input  logic          lp_wr,
    input  logic [AW-1:0] lp_wdata,
    input  logic [PW-1:0] poll_period,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic          rx_err,
    output logic          rx_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_byte,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic [AW-1:0] list_ptr,
    output logic          irq
);

    logic accept;
    logic frame_start;
    logic frame_done;
    logic poll_start;
    logic poll_cancel;
    logic poll_expired;
    logic poll_zero;

    assign poll_zero = (poll_period == '0);

    rxd_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .rx_dis      (rx_dis),
        .frame_start (frame_start),
        .frame_done  (frame_done),
        .accept      (accept)
    );

    rxd_poll_timer #(.PW(PW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (poll_start),
        .cancel  (poll_cancel),
        .period  (poll_period),
        .expired (poll_expired)
    );

    rxd_engine #(.AW(AW), .MAX_FRAGS(MAX_FRAGS)) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt         (halt),
        .resume       (resume),
        .lp_wr        (lp_wr),
        .lp_wdata     (lp_wdata),
        .poll_zero    (poll_zero),
        .poll_expired (poll_expired),
        .poll_start   (poll_start),
        .poll_cancel  (poll_cancel),
        .accept       (accept),
        .frame_start  (frame_start),
        .frame_done   (frame_done),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_last      (rx_last),
        .rx_err       (rx_err),
        .rx_ready     (rx_ready),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_byte     (mem_byte),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .list_ptr     (list_ptr),
        .irq          (irq)
    );

endmodule

// File: rtl/rxd_dma_chk.sv
module rxd_dma_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_ready,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_byte,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic [AW-1:0] list_ptr,
    input logic          irq
);

    // a status write has been acknowledged since the last interrupt
    logic stat_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_seen_q <= 1'b0;
        end else if (irq) begin
            stat_seen_q <= 1'b0;
        end else if (mem_req && mem_ack && mem_we && !mem_byte) begin
            stat_seen_q <= 1'b1;
        end
    end

    // R1 / R4: memory traffic only happens with a live descriptor pointer
    p_req_needs_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (list_ptr != '0));

    // R4: FIFO is only drained while a descriptor is in use
    p_ready_needs_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (list_ptr != '0));

    // R5: a pending request holds its address until acknowledged
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R6: byte accesses are always writes
    p_byte_is_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_byte) |-> mem_we);

    // R7: interrupt is a single-cycle pulse
    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7: interrupt only after the status word went out
    p_irq_after_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat_seen_q);

endmodule

bind rxd_dma rxd_dma_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_ready (rx_ready),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_byte (mem_byte),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .list_ptr (list_ptr),
    .irq      (irq)
);

// File: tb/rxd_dma_test.sv
module rxd_dma_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 0, rx_dis = 0, halt = 0, resume = 0, lp_wr = 0;
    logic [31:0] lp_wdata = '0;
    logic [15:0] poll_period = '0;
    logic        rx_valid = 0, rx_last = 0, rx_err = 0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        mem_req, mem_we, mem_byte;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] list_ptr;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int irq_cnt = 0;
    int stat_reads = 0;
    int cyc = 0;
    logic [31:0] watch_addr = 32'hFFFF_FFFF;

    logic [7:0] mb [0:8191];

    always #5 clk = ~clk;

    rxd_dma uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_dis(rx_dis),
        .halt(halt), .resume(resume), .lp_wr(lp_wr), .lp_wdata(lp_wdata),
        .poll_period(poll_period), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_err(rx_err), .rx_ready(rx_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .list_ptr(list_ptr), .irq(irq)
    );

    function automatic logic [31:0] rd32(input logic [31:0] a);
        return {mb[a[12:0]+13'd3], mb[a[12:0]+13'd2], mb[a[12:0]+13'd1], mb[a[12:0]]};
    endfunction

    task automatic wr32(input logic [31:0] a, input logic [31:0] d);
        mb[a[12:0]]       = d[7:0];
        mb[a[12:0]+13'd1] = d[15:8];
        mb[a[12:0]+13'd2] = d[23:16];
        mb[a[12:0]+13'd3] = d[31:24];
    endtask

    // memory model: one-cycle acknowledge
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                if (mem_byte) mb[mem_addr[12:0]] = mem_wdata[7:0];
                else wr32(mem_addr, mem_wdata);
            end else begin
                mem_rdata <= rd32(mem_addr);
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (irq) irq_cnt <= irq_cnt + 1;
        if (mem_req && mem_ack && !mem_we && mem_addr == watch_addr)
            stat_reads <= stat_reads + 1;
    end

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=<190000 cycles", cyc);
            finish_run();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic set_lp(input logic [31:0] v);
        @(negedge clk); lp_wr = 1'b1; lp_wdata = v;
        @(negedge clk); lp_wr = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] d, input logic [31:0] nxt, input logic [31:0] st,
                            input logic [31:0] a0, input logic [31:0] l0,
                            input logic [31:0] a1, input logic [31:0] l1);
        wr32(d, nxt); wr32(d + 4, st);
        wr32(d + 8, a0); wr32(d + 12, l0);
        wr32(d + 16, a1); wr32(d + 20, l1);
    endtask

    task automatic send_frame(input int n, input logic [7:0] seed, input bit err);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = seed + 8'(i);
            rx_last = (i == n - 1); rx_err = err && (i == n - 1);
            while (!rx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    endtask

    task automatic wait_irq(input string tag, input int target);
        int k = 0;
        while (irq_cnt < target && k < 30000) begin
            @(negedge clk); k++;
        end
        repeat (3) @(negedge clk);
        chk({tag, " irq count"}, irq_cnt, target);
    endtask

    task automatic chk_bytes(input string tag, input logic [31:0] a, input int n, input logic [7:0] seed);
        int bad = 0;
        for (int i = 0; i < n; i++) if (mb[a[12:0] + 13'(i)] !== seed + 8'(i)) bad++;
        chk(tag, bad, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 list_ptr", list_ptr, 0);
        chk("R1 rx_ready", rx_ready, 0);
        chk("R1 irq/mem_req", {irq, mem_req}, 0);
    endtask

    task automatic t_disabled;
        put_desc(32'h100, 0, 0, 32'h1000, 32'h8000_0040, 0, 0);
        set_lp(32'h100);
        fork
            send_frame(10, 8'h10, 0);
            begin
                repeat (100) @(negedge clk);
                chk("R2 ready while disabled", rx_ready, 0);
                chk("R2 status untouched", rd32(32'h104), 0);
                chk("R2 irq", irq_cnt, 0);
                pulse(rx_en);
            end
        join
        wait_irq("R2", 1);
        chk("R7 status single frame", rd32(32'h104), 32'h0000_800A);
        chk_bytes("R6 single fragment bytes", 32'h1000, 10, 8'h10);
        chk("R4 zero next ends list", list_ptr, 0);
    endtask

    task automatic t_multi;
        put_desc(32'h200, 32'h300, 0, 32'h1100, 32'd8, 32'h1200, 32'h8000_0020);
        put_desc(32'h300, 0, 0, 32'h1300, 32'h8000_0010, 0, 0);
        mb[13'h1108] = 8'hEE;
        set_lp(32'h200);
        send_frame(20, 8'h40, 0);
        wait_irq("R6", 2);
        chk_bytes("R6 first fragment", 32'h1100, 8, 8'h40);
        chk_bytes("R5 second fragment pair", 32'h1200, 12, 8'h48);
        chk("R6 no spill past fragment", mb[13'h1108], 8'hEE);
        chk("R4 follows next pointer", list_ptr, 32'h300);
        chk("R7 status split frame", rd32(32'h204), 32'h0000_8014);
        send_frame(5, 8'h70, 0);
        wait_irq("R4", 3);
        chk("R4 chained frame status", rd32(32'h304), 32'h0000_8005);
        chk_bytes("R4 chained frame bytes", 32'h1300, 5, 8'h70);
        chk("R4 end of list", list_ptr, 0);
    endtask

    task automatic t_overflow;
        put_desc(32'h400, 0, 0, 32'h1400, 32'h8000_0008, 0, 0);
        mb[13'h1408] = 8'hEE;
        set_lp(32'h400);
        send_frame(12, 8'h90, 0);
        wait_irq("R8", 4);
        chk("R8 overflow status", rd32(32'h404), 32'h0000_C00C);
        chk_bytes("R8 kept bytes", 32'h1400, 8, 8'h90);
        chk("R8 excess discarded", mb[13'h1408], 8'hEE);
        put_desc(32'h480, 0, 0, 32'h1480, 32'h8000_0040, 0, 0);
        set_lp(32'h480);
        send_frame(6, 8'hA0, 1);
        wait_irq("R8", 5);
        chk("R8 stream error status", rd32(32'h484), 32'h0000_C006);
    endtask

    task automatic t_halt;
        pulse(halt);
        put_desc(32'h500, 0, 0, 32'h1500, 32'h8000_0040, 0, 0);
        set_lp(32'h500);
        fork
            send_frame(7, 8'h21, 0);
            begin
                repeat (100) @(negedge clk);
                chk("R9 halted ready", rx_ready, 0);
                chk("R9 halted status", rd32(32'h504), 0);
                pulse(resume);
            end
        join
        wait_irq("R9", 6);
        chk("R9 after resume", rd32(32'h504), 32'h0000_8007);
    endtask

    task automatic t_owned_halt;
        poll_period = 16'd0;
        put_desc(32'h600, 0, 32'h0000_8003, 32'h1600, 32'h8000_0040, 0, 0);
        set_lp(32'h600);
        fork
            send_frame(9, 8'h31, 0);
            begin
                repeat (100) @(negedge clk);
                chk("R10 no irq on owned", irq_cnt, 6);
                chk("R10 pointer kept", list_ptr, 32'h600);
                chk("R10 status unwritten", rd32(32'h604), 32'h0000_8003);
                wr32(32'h604, 0);
                repeat (50) @(negedge clk);
                chk("R10 stays halted", irq_cnt, 6);
                pulse(resume);
            end
        join
        wait_irq("R10", 7);
        chk("R10 after resume", rd32(32'h604), 32'h0000_8009);
    endtask

    task automatic t_owned_poll;
        poll_period = 16'd16;
        watch_addr = 32'h704;
        put_desc(32'h700, 0, 32'h0000_8003, 32'h1700, 32'h8000_0040, 0, 0);
        set_lp(32'h700);
        fork
            send_frame(4, 8'h51, 0);
            begin
                repeat (120) @(negedge clk);
                chk("R11 no irq while owned", irq_cnt, 7);
                n_chk++;
                if (stat_reads < 3) begin
                    n_fail++;
                    $display("FAIL R11 status rereads: actual=%0d expected=>=3", stat_reads);
                end
                wr32(32'h704, 0);
            end
        join
        wait_irq("R11", 8);
        chk("R11 proceeds without resume", rd32(32'h704), 32'h0000_8004);
        poll_period = 16'd0;
    endtask

    task automatic t_disable_mid;
        put_desc(32'h900, 32'hA00, 0, 32'h1900, 32'h8000_0040, 0, 0);
        put_desc(32'hA00, 0, 0, 32'h1A00, 32'h8000_0040, 0, 0);
        set_lp(32'h900);
        fork
            send_frame(30, 8'h61, 0);
            begin
                repeat (20) @(negedge clk);
                pulse(rx_dis);
            end
        join
        wait_irq("R3", 9);
        chk("R3 frame in progress completes", rd32(32'h904), 32'h0000_801E);
        fork
            send_frame(4, 8'h81, 0);
            begin
                repeat (100) @(negedge clk);
                chk("R3 next frame refused", irq_cnt, 9);
                chk("R3 next desc untouched", rd32(32'hA04), 0);
                pulse(rx_en);
            end
        join
        wait_irq("R3", 10);
        chk("R3 re-enabled", rd32(32'hA04), 32'h0000_8004);
    endtask

    task automatic t_max;
        put_desc(32'hB00, 0, 0, 32'h1800, 32'h8000_05EE, 0, 0);
        set_lp(32'hB00);
        send_frame(1518, 8'h05, 0);
        wait_irq("R12", 11);
        chk("R12 max frame status", rd32(32'hB04), 32'h0000_85EE);
        chk_bytes("R12 max frame bytes", 32'h1800, 1518, 8'h05);
    endtask

    initial begin
        for (int i = 0; i < 8192; i++) mb[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_multi();
        t_overflow();
        t_halt();
        t_owned_halt();
        t_owned_poll();
        t_disable_mid();
        t_max();
        finish_run();
    end

endmodule